// File: doc/BRIEF.md
# Register-Mapped GPIO Controller With Edge Interrupts

This block controls thirteen general-purpose pins through a byte-wide register port. Each pin has two registers. The output-control register holds direction, drive type, pull enable, pull selection and the driven value. The block exports these as control signals to the pad ring and does not model pad electrical behaviour. The input-control register returns the synchronized pin level and chooses which edges of that level count as interrupt events.

Events land in sticky status bits that are split into two groups of unequal size. Pins 0 to 6 form one group and pins 7 to 12 form the other. Each group has a write-one-to-clear status register and a mask register. Every status bit that is set and not masked feeds a single registered, active-high interrupt line. Reads are combinational from the address. A write takes effect on the rising clock edge at which `reg_wr` is high.

With default parameters, output-control registers sit at 0x20 + n and input-control registers at 0x2D + n, where n is the pin number. Status sits at 0x08 (pins 0–6) and 0x09 (pins 7–12), and the masks at 0x0C and 0x0D.

Top module: `edge_gpio_ctrl`

## Requirements
- R1: After reset, every output-control register reads 0x1A (input, push-pull, pull enabled, strong pull-up), every edge-select field is 0, both status registers read 0, the masks read 0x7F and 0x3F, and `irq` is 0.
- R2: The output-control register of pin n is at OUT_BASE+n. The input-control register of pin n is at OUT_BASE+13+n, directly after the last output-control register.
- R3: Output-control bits drive the pin controls: bit 5 is output enable (1 = output), bit 4 is push-pull (0 = open-drain), bit 3 is pull enable, bits 2:1 select the pull (0 strong down, 1 strong up, 2 weak down, 3 weak up) and bit 0 is the output value. Bits 7:6 read 0.
- R4: Input-control bit 0 returns the pin level after a two-flop synchronizer, visible two clock edges after the pin changes. Writes to bit 0 have no effect.
- R5: Input-control bits 2:1 select the edges that raise an event: 0 none, 1 falling, 2 rising, 3 both. An edge is found by comparing the synchronized level with its value one cycle earlier.
- R6: Pin n < 7 maps to bit n of the group-0 status and mask registers. Pin n ≥ 7 maps to bit n−7 of the group-1 registers. Unused upper bits read 0.
- R7: A detected event sets its status bit whether or not the bit is masked. The bit stays set until software clears it.
- R8: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R9: If an event and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R10: `irq` is the OR over both groups of (status AND NOT mask), registered one cycle. A mask bit of 1 blocks that pin.
- R11: Reads of unmapped addresses return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 8 | Register address |
| reg_wr | input | 1 | Write strobe, sampled on the rising edge |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| pin_in | input | 13 | Raw pin levels from the pads |
| pin_out_val | output | 13 | Output value per pin |
| pin_out_en | output | 13 | Output enable per pin |
| pin_push_pull | output | 13 | 1 = push-pull, 0 = open-drain |
| pin_pull_en | output | 13 | Pull resistor enable |
| pin_pull_sel | output | 26 | Pull selection, two bits per pin (pin n at [2n+1:2n]) |
| irq | output | 1 | Interrupt request, active high |

## Verification
The hardest case to reach from the ports is R9: an edge event and a write-one-to-clear that arrive at the same status bit in the same cycle. The event appears only after the pin change has crossed the two-flop synchronizer and the delay stage. The bench therefore changes the pin first and raises the clearing write exactly two rising edges later, so that both land on the third edge. The same write also clears a neighbouring bit that has no event pending. Reading back the status register then shows both outcomes: the bit with the event stays set and the neighbour is cleared.

// File: rtl/egc_pkg.sv
package egc_pkg;

  localparam int DW = 8;

  // reset value of an output-control register: input, push-pull, pull on, strong up
  localparam logic [5:0] OCTL_RST = 6'b01_1_01_0;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'd0,
    EDGE_FALL = 2'd1,
    EDGE_RISE = 2'd2,
    EDGE_ANY  = 2'd3
  } edge_sel_e;

  function automatic logic edge_hit(input logic [1:0] sel, input logic rise, input logic fall);
    return (sel[1] & rise) | (sel[0] & fall);
  endfunction

  function automatic int grp_of(input int pin, input int g0_pins);
    return (pin < g0_pins) ? 0 : 1;
  endfunction

  function automatic int bit_of(input int pin, input int g0_pins);
    return (pin < g0_pins) ? pin : pin - g0_pins;
  endfunction

endpackage

// File: rtl/egc_pin_cell.sv
module egc_pin_cell
  import egc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_out,
  input  logic          wr_in,
  input  logic [DW-1:0] wdata,
  input  logic          pin_raw,
  output logic [5:0]    octl,
  output logic [1:0]    esel,
  output logic          level,
  output logic          evt
);

  logic [5:0] octl_q;
  logic [1:0] esel_q;
  logic       sync1_q, sync2_q, prev_q;
  logic       rise_w, fall_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      octl_q  <= OCTL_RST;
      esel_q  <= EDGE_OFF;
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      prev_q  <= 1'b0;
    end else begin
      sync1_q <= pin_raw;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
      if (wr_out) octl_q <= wdata[5:0];
      if (wr_in)  esel_q <= wdata[2:1];
    end
  end

  assign rise_w = sync2_q & ~prev_q;
  assign fall_w = ~sync2_q & prev_q;
  assign evt    = edge_hit(esel_q, rise_w, fall_w);
  assign octl   = octl_q;
  assign esel   = esel_q;
  assign level  = sync2_q;

  // R5: a falling-only event always leaves the level low
  a_r5_fall_low: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && esel_q == EDGE_FALL) |-> !sync2_q);
  // R5: a rising-only event always leaves the level high
  a_r5_rise_high: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && esel_q == EDGE_RISE) |-> sync2_q);
  // R3: the control byte only changes on its own write
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_out |=> $stable(octl_q));

endmodule

// File: rtl/egc_irq_group.sv
module egc_irq_group
  import egc_pkg::*;
#(
  parameter int W = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  ev,
  input  logic          wr_stat,
  input  logic          wr_mask,
  input  logic [DW-1:0] wdata,
  output logic [W-1:0]  status,
  output logic [W-1:0]  mask,
  output logic          pending
);

  logic [W-1:0] status_q, mask_q, clr_w;

  assign clr_w = wr_stat ? wdata[W-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      mask_q   <= '1;
    end else begin
      status_q <= (status_q & ~clr_w) | ev;
      if (wr_mask) mask_q <= wdata[W-1:0];
    end
  end

  assign status  = status_q;
  assign mask    = mask_q;
  assign pending = |(status_q & ~mask_q);

  // R9: an event is never lost, even under a simultaneous clear
  a_r9_event_kept: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & $past(ev)) == $past(ev)));
  // R8: a cleared bit without an event goes to zero
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & $past(clr_w & ~ev)) == '0));
  // R7: a set bit stays set unless a one is written to it
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(status_q) & ~$past(clr_w) & ~status_q) == '0));

endmodule

// File: rtl/edge_gpio_ctrl.sv
module edge_gpio_ctrl
  import egc_pkg::*;
#(
  parameter int NPIN      = 13,
  parameter int G0        = 7,
  parameter int AW        = 8,
  parameter int OUT_BASE  = 'h20,
  parameter int STAT_BASE = 'h08,
  parameter int MASK_BASE = 'h0C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     reg_addr,
  input  logic              reg_wr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic [NPIN-1:0]   pin_in,
  output logic [NPIN-1:0]   pin_out_val,
  output logic [NPIN-1:0]   pin_out_en,
  output logic [NPIN-1:0]   pin_push_pull,
  output logic [NPIN-1:0]   pin_pull_en,
  output logic [2*NPIN-1:0] pin_pull_sel,
  output logic              irq
);

  localparam int IN_BASE = OUT_BASE + NPIN;
  localparam int G1      = NPIN - G0;

  logic [5:0]      octl [NPIN];
  logic [1:0]      esel [NPIN];
  logic [NPIN-1:0] lvl, ev;
  logic [G0-1:0]   stat0, mask0;
  logic [G1-1:0]   stat1, mask1;
  logic            pend0, pend1, irq_q;

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    logic wr_o, wr_i;
    assign wr_o = reg_wr && (reg_addr == AW'(OUT_BASE + i));
    assign wr_i = reg_wr && (reg_addr == AW'(IN_BASE + i));

    egc_pin_cell u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_out  (wr_o),
      .wr_in   (wr_i),
      .wdata   (reg_wdata),
      .pin_raw (pin_in[i]),
      .octl    (octl[i]),
      .esel    (esel[i]),
      .level   (lvl[i]),
      .evt     (ev[i])
    );

    assign pin_out_en[i]          = octl[i][5];
    assign pin_push_pull[i]       = octl[i][4];
    assign pin_pull_en[i]         = octl[i][3];
    assign pin_pull_sel[2*i +: 2] = octl[i][2:1];
    assign pin_out_val[i]         = octl[i][0];
  end

  egc_irq_group #(.W(G0)) u_grp0 (
    .clk     (clk),
    .rst_n   (rst_n),
    .ev      (ev[G0-1:0]),
    .wr_stat (reg_wr && (reg_addr == AW'(STAT_BASE))),
    .wr_mask (reg_wr && (reg_addr == AW'(MASK_BASE))),
    .wdata   (reg_wdata),
    .status  (stat0),
    .mask    (mask0),
    .pending (pend0)
  );

  egc_irq_group #(.W(G1)) u_grp1 (
    .clk     (clk),
    .rst_n   (rst_n),
    .ev      (ev[NPIN-1:G0]),
    .wr_stat (reg_wr && (reg_addr == AW'(STAT_BASE + 1))),
    .wr_mask (reg_wr && (reg_addr == AW'(MASK_BASE + 1))),
    .wdata   (reg_wdata),
    .status  (stat1),
    .mask    (mask1),
    .pending (pend1)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= pend0 | pend1;
  end
  assign irq = irq_q;

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NPIN; i++) begin
      if (reg_addr == AW'(OUT_BASE + i)) reg_rdata = {2'b00, octl[i]};
      if (reg_addr == AW'(IN_BASE + i))  reg_rdata = {5'b0, esel[i], lvl[i]};
    end
    if (reg_addr == AW'(STAT_BASE))     reg_rdata[G0-1:0] = stat0;
    if (reg_addr == AW'(STAT_BASE + 1)) reg_rdata[G1-1:0] = stat1;
    if (reg_addr == AW'(MASK_BASE))     reg_rdata[G0-1:0] = mask0;
    if (reg_addr == AW'(MASK_BASE + 1)) reg_rdata[G1-1:0] = mask1;
  end

  // R10: irq follows the unmasked pending state of both groups one cycle later
  a_r10_irq_follow: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == $past(pend0 | pend1)));

endmodule

// File: tb/edge_gpio_ctrl_test.sv
`timescale 1ns/1ps
module edge_gpio_ctrl_test;

  localparam int NP = 13, G0 = 7;
  localparam int OB = 'h20, IB = 'h2D, SB = 'h08, MB = 'h0C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic [12:0] pin_in = '0;
  logic [12:0] pin_out_val, pin_out_en, pin_push_pull, pin_pull_en;
  logic [25:0] pin_pull_sel;
  logic        irq;

  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  edge_gpio_ctrl uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
    .pin_out_val(pin_out_val), .pin_out_en(pin_out_en),
    .pin_push_pull(pin_push_pull), .pin_pull_en(pin_pull_en),
    .pin_pull_sel(pin_pull_sel), .irq(irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_addr = 8'(a); reg_wdata = 8'(d); reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = 8'(a);
    #1 d = reg_rdata;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  function automatic int sa(input int p); return (p < G0) ? SB : SB + 1; endfunction
  function automatic int sb(input int p); return (p < G0) ? p : p - G0; endfunction

  initial begin
    #(200000 * 20);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(2);

    // R1 reset state
    for (int p = 0; p < NP; p++) begin
      rd(OB + p, d); check("R1 out reset", d, 8'h1A);
      rd(IB + p, d); check("R1 in reset", d, 8'h00);
    end
    rd(SB, d);     check("R1 stat0", d, 8'h00);
    rd(SB + 1, d); check("R1 stat1", d, 8'h00);
    rd(MB, d);     check("R1 R6 mask0", d, 8'h7F);
    rd(MB + 1, d); check("R1 R6 mask1", d, 8'h3F);
    check("R1 irq", {7'b0, irq}, 8'h00);

    // R2 R3 output-control sweep: unique value per pin, upper bits written as ones
    for (int p = 0; p < NP; p++) wr(OB + p, 8'hC0 | ((p * 7 + 5) & 8'h3F));
    for (int p = 0; p < NP; p++) begin
      logic [7:0] e;
      e = 8'((p * 7 + 5) & 8'h3F);
      rd(OB + p, d); check("R2 R3 readback", d, e);
      check("R3 pin controls",
            {2'b00, pin_out_en[p], pin_push_pull[p], pin_pull_en[p],
             pin_pull_sel[2*p +: 2], pin_out_val[p]}, e);
    end

    // R4 level sweep over two patterns
    for (int pat = 0; pat < 2; pat++) begin
      logic [12:0] v;
      v = (pat == 0) ? 13'h0A5B : 13'h15A4;
      @(negedge clk); pin_in = v;
      idle(3);
      for (int p = 0; p < NP; p++) begin
        rd(IB + p, d); check("R4 level", d, {7'b0, v[p]});
      end
    end
    @(negedge clk); pin_in = '0; idle(3);
    wr(IB + 2, 8'h01);
    rd(IB + 2, d); check("R4 bit0 write ignored", d, 8'h00);

    // R5 R6 R7 edge-select sweep on every pin, all masked
    for (int p = 0; p < NP; p++) begin
      for (int m = 0; m < 4; m++) begin
        wr(IB + p, m << 1);
        wr(sa(p), 8'hFF);
        @(negedge clk); pin_in[p] = 1'b1; idle(4);
        rd(sa(p), d); check("R5 R6 R7 rise", d, 8'((m >> 1) << sb(p)));
        wr(sa(p), 8'hFF);
        @(negedge clk); pin_in[p] = 1'b0; idle(4);
        rd(sa(p), d); check("R5 R6 fall", d, 8'((m & 1) << sb(p)));
        wr(sa(p), 8'hFF);
      end
      wr(IB + p, 0);
    end
    check("R10 masked irq low", {7'b0, irq}, 8'h00);

    // R7 R8 R10 mask and clear
    wr(IB + 3, 8'h04);
    @(negedge clk); pin_in[3] = 1'b1; idle(4);
    rd(SB, d); check("R7 masked status set", d, 8'h08);
    check("R10 still masked", {7'b0, irq}, 8'h00);
    wr(SB, 8'h00);
    rd(SB, d); check("R8 write zero keeps", d, 8'h08);
    wr(MB, 8'h77);
    idle(1);
    check("R10 irq on unmask", {7'b0, irq}, 8'h01);
    wr(SB, 8'h08);
    idle(1);
    check("R10 irq after clear", {7'b0, irq}, 8'h00);
    rd(SB, d); check("R8 cleared", d, 8'h00);
    wr(MB, 8'h7F);

    // R9 event and clear on the same edge
    wr(IB + 9, 8'h06);
    wr(IB + 10, 8'h04);
    wr(SB + 1, 8'hFF);
    @(negedge clk); pin_in[9] = 1'b1; pin_in[10] = 1'b1; idle(4);
    rd(SB + 1, d); check("R9 setup", d, 8'h0C);
    @(negedge clk); pin_in[9] = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk); reg_addr = 8'(SB + 1); reg_wdata = 8'h0C; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
    rd(SB + 1, d); check("R9 event wins", d, 8'h04);

    // R11 unmapped addresses
    rd(8'h00, d); check("R11 read 00", d, 8'h00);
    rd(8'h0A, d); check("R11 read 0A", d, 8'h00);
    rd(8'h0E, d); check("R11 read 0E", d, 8'h00);
    rd(8'h3A, d); check("R11 read 3A", d, 8'h00);
    rd(8'hFF, d); check("R11 read FF", d, 8'h00);
    wr(8'h0A, 8'hFF); wr(8'h3A, 8'hFF); wr(8'h0E, 8'h00);
    rd(MB, d);     check("R11 mask0 unchanged", d, 8'h7F);
    rd(MB + 1, d); check("R11 mask1 unchanged", d, 8'h3F);
    rd(OB, d);     check("R11 out0 unchanged", d, 8'h05);
    rd(SB + 1, d); check("R11 stat1 unchanged", d, 8'h04);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule